// File: doc/BRIEF.md
# SD 4-bit Data Receive Path with Read-Wait

This block is the host side of a 4-bit SD/SDIO data path for block reads. Once software loads a block length (in bytes) and a block count and pulses the start control, the block waits for the card to open each block with a start bit. It then gathers the nibbles into bytes, checks the closing end bit and counts the blocks down until the transfer is complete. Received bytes leave on a simple valid-qualified byte stream. The stream stands in for a FIFO and has no backpressure.

A read-wait request pauses the transfer only at a block boundary. While paused, the host pulls DAT[2] low to tell the card to wait. The block count, the done flag and the error flag hold their values, and the bus clock enable stays asserted. The command serializer can still send frames on CMD during the pause. After a resume pulse, the transfer picks up with the next remaining block. Between blocks, the block watches DAT[1] for a card interrupt.

The model carries one bus bit time per system clock cycle. CRC, response parsing and DMA are not part of this block.

Top module: `sd_rw_host`

## Requirements
- R1: A block is accepted when all four DAT lines are sampled low (start bit) while the transfer is armed. The next 2×length samples are nibbles, high nibble first. Each completed byte produces a one-cycle `rx_valid` pulse carrying that byte.
- R2: The sample after the last nibble is the end bit and must be 4'hF. Any other value sets `end_err`, which stays set until the next accepted start.
- R3: `blocks_left` decrements by one at each end bit. When it reaches zero, `xfer_busy` falls and `xfer_done` rises. `xfer_done` stays set until the next start.
- R4: A read-wait request made during a transfer takes effect only at a block boundary. If it arrives mid-block, `rw_active` stays low until the cycle after the end bit has been sampled.
- R5: While `rw_active` is high, `dat_oe` is 4'b0100 and `dat_out[2]` is 0. All other DAT lines are released.
- R6: `sd_clk_en` stays high for the whole read-wait period.
- R7: During read-wait, `blocks_left`, `xfer_done` and `end_err` hold their values. Start-bit patterns on DAT are ignored and no byte is produced.
- R8: While idle, a `cmd_go` pulse sends `cmd_word` MSB first on `cmd_out`, one bit per cycle, with `cmd_oe` high. The first bit appears the cycle after the pulse. This works the same during read-wait.
- R9: After a `rw_resume` pulse, `rw_active` and `dat_oe` clear on the next cycle. Reception then continues with the remaining blocks and the count is not reloaded.
- R10: A read-wait request while no transfer is busy has no effect on `rw_active` or `dat_oe`. It sets `rw_ignored`, which the next start clears.
- R11: The card interrupt (DAT[1] low with DAT[0] high) is sampled only between blocks. This means after at least one block of the current transfer has ended, while busy and not in or pending read-wait, and while waiting for a start bit. When sampled, `card_irq` is high on the following cycle. A low DAT[1] inside a block never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one bus bit time per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | Start pulse, ignored while busy |
| blk_len | input | LEN_W | Block length in bytes (at least 1) |
| blk_cnt | input | CNT_W | Number of blocks |
| rw_req | input | 1 | Read-wait request pulse |
| rw_resume | input | 1 | Leave read-wait pulse |
| cmd_go | input | 1 | Send a command frame |
| cmd_word | input | CMD_BITS | Command frame, MSB sent first |
| dat_in | input | 4 | Sampled DAT[3:0] |
| dat_out | output | 4 | DAT drive values |
| dat_oe | output | 4 | DAT drive enables |
| cmd_out | output | 1 | CMD drive value |
| cmd_oe | output | 1 | CMD drive enable |
| cmd_busy | output | 1 | Command frame in flight |
| sd_clk_en | output | 1 | Bus clock enable |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Byte strobe |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | Transfer completed (sticky) |
| end_err | output | 1 | Bad end bit seen (sticky) |
| rw_active | output | 1 | Read-wait in effect |
| rw_ignored | output | 1 | Request made while idle (sticky) |
| blocks_left | output | CNT_W | Remaining blocks |
| card_irq | output | 1 | Card interrupt sampled |

## Verification
The checker enforces several properties on every cycle. These cover the DAT[2] drive pattern, the running clock enable, the frozen count and flags, and the absence of byte strobes during read-wait. They also cover the one-step descent of the block count, the done flag when busy falls, the rule that an idle request never starts a wait, and the rule that an interrupt is flagged only while a transfer is running. Some behaviour can only be shown by the bench's scenarios. This includes the deferral of a mid-block request to the boundary, byte ordering across different data patterns, end-bit error reporting, a full command frame sent during the pause, and resumption with no repeated or lost block.

// File: rtl/sd_rw_pkg.sv
// Shared types and constants for the SD read-wait data path.
// Assumes a 4-bit data bus sampled once per system clock.
package sd_rw_pkg;
    typedef enum logic [1:0] {
        DF_IDLE = 2'd0,
        DF_DATA = 2'd1,
        DF_END  = 2'd2
    } df_state_t;

    localparam logic [3:0] DAT_IDLE_HIGH = 4'hF;
    localparam logic [3:0] DAT_START     = 4'h0;
    localparam logic [3:0] RW_DRIVE_MASK = 4'b0100;
endpackage

// File: rtl/sd_rx_deframer.sv
// Block deframer: finds the start bit, packs nibbles into bytes
// (high nibble first) and checks the end bit.
// Assumes blk_len >= 1 and stable while a block is in progress.
module sd_rx_deframer
    import sd_rw_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [3:0]       dat_in,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             blk_done,
    output logic             end_bad,
    output logic             idle
);
    df_state_t      state;
    logic [LEN_W:0] nib_cnt;
    logic [LEN_W:0] last_nib;
    logic [3:0]     hi_nib;

    // Index of the final nibble of the block.
    always_comb last_nib = {blk_len, 1'b0} - 1'b1;

    // Frame sequencer and byte packer (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= DF_IDLE;
            nib_cnt  <= '0;
            hi_nib   <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            case (state)
                DF_IDLE: begin
                    if (arm && dat_in == DAT_START) begin
                        state   <= DF_DATA;
                        nib_cnt <= '0;
                    end
                end
                DF_DATA: begin
                    if (!nib_cnt[0]) begin
                        hi_nib <= dat_in;
                    end else begin
                        rx_data  <= {hi_nib, dat_in};
                        rx_valid <= 1'b1;
                    end
                    if (nib_cnt == last_nib) begin
                        state <= DF_END;
                    end
                    nib_cnt <= nib_cnt + 1'b1;
                end
                DF_END:  state <= DF_IDLE;
                default: state <= DF_IDLE;
            endcase
        end
    end

    // End-bit strobes (R2, R3).
    always_comb begin
        blk_done = (state == DF_END);
        end_bad  = (state == DF_END) && (dat_in != DAT_IDLE_HIGH);
        idle     = (state == DF_IDLE);
    end
endmodule

// File: rtl/sd_cmd_shifter.sv
// Command serializer: shifts a frame out on CMD, MSB first.
// Works independently of the data path, so it runs during read-wait.
module sd_cmd_shifter #(
    parameter int CMD_BITS = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [CMD_BITS-1:0] word,
    output logic                busy,
    output logic                cmd_out,
    output logic                cmd_oe
);
    localparam int CW = $clog2(CMD_BITS + 1);

    logic [CMD_BITS-1:0] sreg;
    logic [CW-1:0]       bits_left;

    // Load on go when idle, then shift one bit per cycle (R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg      <= '0;
            bits_left <= '0;
        end else if (bits_left == '0) begin
            if (go) begin
                sreg      <= word;
                bits_left <= CW'(CMD_BITS);
            end
        end else begin
            sreg      <= {sreg[CMD_BITS-2:0], 1'b1};
            bits_left <= bits_left - 1'b1;
        end
    end

    // Line drive: release and idle high when not sending.
    always_comb begin
        busy    = (bits_left != '0);
        cmd_oe  = busy;
        cmd_out = busy ? sreg[CMD_BITS-1] : 1'b1;
    end
endmodule

// File: rtl/sd_xfer_ctrl.sv
// Transfer controller: block counting, sticky status, read-wait
// sequencing and the card-interrupt window.
// Assumes deframer strobes arrive in the cycle the end bit is sampled.
module sd_xfer_ctrl #(
    parameter int LEN_W = 10,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [CNT_W-1:0] blk_cnt,
    input  logic             rw_req,
    input  logic             rw_resume,
    input  logic             df_idle,
    input  logic             blk_done,
    input  logic             end_bad,
    input  logic [1:0]       dat_lo,
    output logic [LEN_W-1:0] len_q,
    output logic             df_arm,
    output logic             xfer_busy,
    output logic             xfer_done,
    output logic             end_err,
    output logic             rw_active,
    output logic             rw_ignored,
    output logic [CNT_W-1:0] blocks_left,
    output logic             card_irq
);
    logic rw_pend;
    logic seen_blk;
    logic start_ok;
    logic last_blk;
    logic irq_window;

    always_comb begin
        start_ok   = xfer_start && !xfer_busy;
        last_blk   = blk_done && (blocks_left == CNT_W'(1));
        df_arm     = xfer_busy && !rw_active && !rw_pend;
        irq_window = xfer_busy && seen_blk && df_idle && !rw_active && !rw_pend;
    end

    // Block counter and sticky transfer status (R2, R3).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q       <= '0;
            blocks_left <= '0;
            xfer_busy   <= 1'b0;
            xfer_done   <= 1'b0;
            end_err     <= 1'b0;
            seen_blk    <= 1'b0;
        end else if (start_ok) begin
            len_q       <= blk_len;
            blocks_left <= blk_cnt;
            xfer_busy   <= (blk_cnt != '0);
            xfer_done   <= (blk_cnt == '0);
            end_err     <= 1'b0;
            seen_blk    <= 1'b0;
        end else if (xfer_busy && blk_done) begin
            blocks_left <= blocks_left - 1'b1;
            seen_blk    <= 1'b1;
            end_err     <= end_err | end_bad;
            if (last_blk) begin
                xfer_busy <= 1'b0;
                xfer_done <= 1'b1;
            end
        end
    end

    // Read-wait sequencing: boundary-only entry, resume, idle rejection (R4, R9, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_pend    <= 1'b0;
            rw_active  <= 1'b0;
            rw_ignored <= 1'b0;
        end else if (start_ok) begin
            rw_pend    <= 1'b0;
            rw_active  <= 1'b0;
            rw_ignored <= 1'b0;
        end else if (!xfer_busy) begin
            rw_pend   <= 1'b0;
            rw_active <= 1'b0;
            if (rw_req) begin
                rw_ignored <= 1'b1;
            end
        end else if (last_blk) begin
            rw_pend <= 1'b0;
        end else if (rw_active) begin
            if (rw_resume) begin
                rw_active <= 1'b0;
            end
        end else if (rw_pend) begin
            if (df_idle) begin
                rw_active <= 1'b1;
                rw_pend   <= 1'b0;
            end
        end else if (rw_req) begin
            rw_pend <= 1'b1;
        end
    end

    // Card interrupt sampled on DAT[1] only between blocks (R11).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card_irq <= 1'b0;
        end else begin
            card_irq <= irq_window && !dat_lo[1] && dat_lo[0];
        end
    end
endmodule

// File: rtl/sd_rw_host.sv
// Top of the SD 4-bit receive path with read-wait. Ties the deframer,
// transfer controller and command serializer together and drives DAT[2]
// low during read-wait. One bus bit time per clk cycle.
module sd_rw_host
    import sd_rw_pkg::*;
#(
    parameter int LEN_W    = 10,
    parameter int CNT_W    = 8,
    parameter int CMD_BITS = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer_start,
    input  logic [LEN_W-1:0]    blk_len,
    input  logic [CNT_W-1:0]    blk_cnt,
    input  logic                rw_req,
    input  logic                rw_resume,
    input  logic                cmd_go,
    input  logic [CMD_BITS-1:0] cmd_word,
    input  logic [3:0]          dat_in,
    output logic [3:0]          dat_out,
    output logic [3:0]          dat_oe,
    output logic                cmd_out,
    output logic                cmd_oe,
    output logic                cmd_busy,
    output logic                sd_clk_en,
    output logic [7:0]          rx_data,
    output logic                rx_valid,
    output logic                xfer_busy,
    output logic                xfer_done,
    output logic                end_err,
    output logic                rw_active,
    output logic                rw_ignored,
    output logic [CNT_W-1:0]    blocks_left,
    output logic                card_irq
);
    logic [LEN_W-1:0] len_q;
    logic             df_arm;
    logic             df_idle;
    logic             blk_done;
    logic             end_bad;

    sd_rx_deframer #(.LEN_W(LEN_W)) u_deframer (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (df_arm),
        .blk_len  (len_q),
        .dat_in   (dat_in),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .blk_done (blk_done),
        .end_bad  (end_bad),
        .idle     (df_idle)
    );

    sd_xfer_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_start  (xfer_start),
        .blk_len     (blk_len),
        .blk_cnt     (blk_cnt),
        .rw_req      (rw_req),
        .rw_resume   (rw_resume),
        .df_idle     (df_idle),
        .blk_done    (blk_done),
        .end_bad     (end_bad),
        .dat_lo      (dat_in[1:0]),
        .len_q       (len_q),
        .df_arm      (df_arm),
        .xfer_busy   (xfer_busy),
        .xfer_done   (xfer_done),
        .end_err     (end_err),
        .rw_active   (rw_active),
        .rw_ignored  (rw_ignored),
        .blocks_left (blocks_left),
        .card_irq    (card_irq)
    );

    sd_cmd_shifter #(.CMD_BITS(CMD_BITS)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (cmd_go),
        .word    (cmd_word),
        .busy    (cmd_busy),
        .cmd_out (cmd_out),
        .cmd_oe  (cmd_oe)
    );

    // Bus drive: hold DAT[2] low in read-wait, keep clock on while busy (R5, R6).
    always_comb begin
        dat_oe    = rw_active ? RW_DRIVE_MASK : 4'h0;
        dat_out   = rw_active ? ~RW_DRIVE_MASK : DAT_IDLE_HIGH;
        sd_clk_en = xfer_busy || cmd_busy;
    end
endmodule

// File: rtl/sd_rw_host_chk.sv
// Assertion checker for sd_rw_host, attached by bind below.
module sd_rw_host_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rw_req,
    input logic             xfer_busy,
    input logic             xfer_done,
    input logic             end_err,
    input logic             rw_active,
    input logic [3:0]       dat_oe,
    input logic [3:0]       dat_out,
    input logic             sd_clk_en,
    input logic             rx_valid,
    input logic             card_irq,
    input logic [CNT_W-1:0] blocks_left
);
    a_r5_dat2_low: assert property (@(posedge clk) disable iff (!rst_n)
        rw_active |-> (dat_oe == 4'b0100 && !dat_out[2]));

    a_r6_clk_running: assert property (@(posedge clk) disable iff (!rst_n)
        rw_active |-> sd_clk_en);

    a_r7_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rw_active |=> ($stable(blocks_left) && $stable(xfer_done) && $stable(end_err)));

    a_r7_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        rw_active |-> !rx_valid);

    a_r10_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_req && !xfer_busy) |=> !rw_active);

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |=> (blocks_left == $past(blocks_left) ||
                       blocks_left == $past(blocks_left) - 1'b1));

    a_r3_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_busy) |-> (xfer_done && blocks_left == '0));

    a_r11_irq_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        card_irq |-> (xfer_busy && !rw_active));
endmodule

bind sd_rw_host sd_rw_host_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rw_req      (rw_req),
    .xfer_busy   (xfer_busy),
    .xfer_done   (xfer_done),
    .end_err     (end_err),
    .rw_active   (rw_active),
    .dat_oe      (dat_oe),
    .dat_out     (dat_out),
    .sd_clk_en   (sd_clk_en),
    .rx_valid    (rx_valid),
    .card_irq    (card_irq),
    .blocks_left (blocks_left)
);

// File: tb/sd_rw_host_test.sv
`timescale 1ns/1ps
module sd_rw_host_test;
    localparam int LEN_W = 10;
    localparam int CNT_W = 8;
    localparam int CMD_BITS = 48;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                xfer_start = 1'b0;
    logic [LEN_W-1:0]    blk_len = '0;
    logic [CNT_W-1:0]    blk_cnt = '0;
    logic                rw_req = 1'b0;
    logic                rw_resume = 1'b0;
    logic                cmd_go = 1'b0;
    logic [CMD_BITS-1:0] cmd_word = '0;
    logic [3:0]          dat_in = 4'hF;
    logic [3:0]          dat_out, dat_oe;
    logic                cmd_out, cmd_oe, cmd_busy, sd_clk_en;
    logic [7:0]          rx_data;
    logic                rx_valid, xfer_busy, xfer_done, end_err;
    logic                rw_active, rw_ignored, card_irq;
    logic [CNT_W-1:0]    blocks_left;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    sd_rw_host #(.LEN_W(LEN_W), .CNT_W(CNT_W), .CMD_BITS(CMD_BITS)) uut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .blk_len(blk_len),
        .blk_cnt(blk_cnt), .rw_req(rw_req), .rw_resume(rw_resume),
        .cmd_go(cmd_go), .cmd_word(cmd_word), .dat_in(dat_in),
        .dat_out(dat_out), .dat_oe(dat_oe), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .cmd_busy(cmd_busy), .sd_clk_en(sd_clk_en), .rx_data(rx_data),
        .rx_valid(rx_valid), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
        .end_err(end_err), .rw_active(rw_active), .rw_ignored(rw_ignored),
        .blocks_left(blocks_left), .card_irq(card_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic [3:0] nib, input bit rw);
        @(negedge clk);
        dat_in = nib;
        rw_req = rw;
    endtask

    // Driver: frames a block on DAT and pushes the expected bytes.
    task automatic send_block(input logic [7:0] data [4], input int n,
                              input logic [3:0] endv, input int rw_at);
        send_bit(4'h0, 1'b0);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(data[i]);
            send_bit(data[i][7:4], (2 * i) == rw_at);
            send_bit(data[i][3:0], (2 * i + 1) == rw_at);
        end
        if (rw_at >= 0) begin
            // R4: still inside the block, the request must not have taken hold
            check(rw_active == 1'b0, "R4 deferred", rw_active, 0);
            // R11: DAT[1] low nibbles inside a block raise no interrupt
            check(card_irq == 1'b0, "R11 no irq in block", card_irq, 0);
        end
        send_bit(endv, 1'b0);
    endtask

    // Monitor: pops and compares each produced byte (R1, R7).
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1/R7 unexpected byte", rx_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rx_data == e, "R1 byte", rx_data, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] blk_a [4];
        logic [7:0] blk_b [4];
        logic [7:0] blk_c [4];
        logic [7:0] blk_d [4];
        logic [CMD_BITS-1:0] cw;
        int bad;
        blk_a = '{8'h12, 8'h34, 8'hAB, 8'hCD};
        blk_b = '{8'hD5, 8'h1D, 8'h3C, 8'hDD};
        blk_c = '{8'h01, 8'h23, 8'h45, 8'h67};
        blk_d = '{8'hF0, 8'h0F, 8'h00, 8'h00};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!xfer_busy && !xfer_done && !rw_active && dat_oe == 4'h0 &&
              !sd_clk_en && !cmd_oe && blocks_left == 0, "R3 reset state",
              {xfer_busy, xfer_done, rw_active, sd_clk_en}, 0);

        // R10: request while idle is ignored and flagged
        rw_req = 1'b1;
        @(negedge clk);
        rw_req = 1'b0;
        check(rw_ignored == 1'b1, "R10 flagged", rw_ignored, 1);
        check(!rw_active && dat_oe == 4'h0, "R10 no wait", dat_oe, 0);

        // Start: 4-byte blocks, three of them
        blk_len = 10'd4;
        blk_cnt = 8'd3;
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        check(xfer_busy && sd_clk_en && blocks_left == 3 && !rw_ignored,
              "R3/R10 start", blocks_left, 3);

        send_bit(4'hF, 1'b0);
        send_block(blk_a, 4, 4'hF, -1);
        send_bit(4'hF, 1'b0);
        check(blocks_left == 2, "R3 decrement", blocks_left, 2);

        // R11: interrupt between blocks
        send_bit(4'hD, 1'b0);
        send_bit(4'hF, 1'b0);
        check(card_irq == 1'b1, "R11 irq between blocks", card_irq, 1);

        // R4: read-wait request in the middle of block B
        send_block(blk_b, 4, 4'hF, 2);
        send_bit(4'hF, 1'b0);
        send_bit(4'hF, 1'b0);
        check(rw_active == 1'b1, "R4 entered at boundary", rw_active, 1);
        check(dat_oe == 4'b0100 && dat_out[2] == 1'b0, "R5 DAT2 low", dat_oe, 4);
        check(sd_clk_en == 1'b1, "R6 clock on", sd_clk_en, 1);
        check(blocks_left == 1, "R3 second block", blocks_left, 1);

        // R7: start patterns during wait are ignored, state held
        repeat (6) send_bit(4'h0, 1'b0);
        check(blocks_left == 1 && !xfer_done && rw_active, "R7 frozen", blocks_left, 1);

        // R8: command during read-wait
        cw = 48'hA5_1234_5678_9C;
        @(negedge clk);
        cmd_word = cw;
        cmd_go = 1'b1;
        bad = 0;
        for (int k = 0; k < CMD_BITS; k++) begin
            @(negedge clk);
            cmd_go = 1'b0;
            if (cmd_out !== cw[CMD_BITS-1-k] || !cmd_oe) bad++;
        end
        check(bad == 0, "R8 cmd bits", bad, 0);
        @(negedge clk);
        check(!cmd_busy && rw_active && sd_clk_en, "R8/R6 after cmd", cmd_busy, 0);

        // R9: resume, then the last block with a bad end bit (R2)
        dat_in = 4'hF;
        rw_resume = 1'b1;
        @(negedge clk);
        rw_resume = 1'b0;
        check(!rw_active && dat_oe == 4'h0, "R9 resume", rw_active, 0);
        check(blocks_left == 1, "R9 no reload", blocks_left, 1);
        send_block(blk_c, 4, 4'h7, -1);
        send_bit(4'hF, 1'b0);
        check(blocks_left == 0 && !xfer_busy && xfer_done, "R3/R9 done",
              blocks_left, 0);
        check(end_err == 1'b1, "R2 bad end", end_err, 1);

        // Second transfer: 2-byte block, clean end
        blk_len = 10'd2;
        blk_cnt = 8'd1;
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        check(!end_err && !xfer_done && blocks_left == 1, "R2 cleared", end_err, 0);
        send_block(blk_d, 2, 4'hF, -1);
        send_bit(4'hF, 1'b0);
        check(xfer_done && !end_err && blocks_left == 0, "R1/R2 short block",
              end_err, 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R1 all bytes seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule